// File: doc/BRIEF.md
# FIFO Watermark Interrupt and DMA Request Controller

This block sits beside the transmit and receive FIFOs of a serial controller and turns their occupancy into status flags, interrupts and DMA requests. It takes the two entry counts, single-cycle error pulses (a push into a full FIFO, a pop from an empty one) and register-style control inputs: thresholds, mask bits, an output polarity select, DMA enables with their levels, and a write-one clear strobe. The FIFO storage, the bus decoder and the shift engine are outside it.

Two kinds of interrupt source exist. The watermark sources follow the counts as levels. The transmit source fires while the count is at or below its threshold. The receive source fires while the count is at least its threshold plus one. The error sources are sticky: once set, each holds until software clears it through the clear vector. The five raw sources are masked, each masked bit is driven out on its own pin, and their OR forms one combined interrupt whose active level is selectable. The two DMA request lines use the same two comparison rules against their own levels, and an acknowledge drops the request for a cycle. When the controller is disabled, both counts are treated as zero.

Top module: `fifo_irq_dma_ctl`

## Requirements
- R1: While reset is low, the status word is 0x0C, the raw vector is 0x01 and both DMA requests are 0.
- R2: One cycle after the inputs are sampled, raw bit 0 (transmit empty) is 1 exactly when the effective transmit count is less than or equal to the transmit threshold.
- R3: One cycle after the inputs are sampled, raw bit 4 (receive full) is 1 exactly when the effective receive count is greater than or equal to the receive threshold plus one. A threshold of 31 fires only at a count of 32.
- R4: A pulse on the transmit push-full, receive pop-empty or receive push-full input sets raw bit 1, bit 2 or bit 3 respectively on the next edge. The bit then stays set until it is cleared.
- R5: A clear strobe with clear bit 3 clears raw bit 1, with bit 2 clears raw bit 3, and with bit 1 clears raw bit 2. Clear bit 0 clears all three. A set pulse in the same cycle wins over a clear. Raw bits 0 and 4 are not affected by a clear.
- R6: The masked vector equals the raw vector ANDed with the mask, where a mask bit of 1 enables its source. The five individual interrupt pins carry masked bits 0 to 4.
- R7: The combined interrupt is the OR of the masked bits when the polarity input is 0, and its inverse when the polarity input is 1.
- R8: The transmit DMA request is registered. It is 1 after an edge when, in the preceding cycle, transmit DMA was enabled, the effective transmit count was at or below the transmit DMA level, and the transmit acknowledge was low.
- R9: The receive DMA request is registered. It is 1 after an edge when, in the preceding cycle, receive DMA was enabled, the effective receive count was at or above the receive DMA level plus one, and the receive acknowledge was low.
- R10: The status word is registered with busy in bit 0, transmit full (count 32) in bit 1, transmit empty in bit 2, receive empty in bit 3 and receive full in bit 4.
- R11: While the enable input is low, both effective counts are zero. The status therefore shows both FIFOs empty and neither full, raw bit 4 is 0, and raw bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en | input | 1 | Controller enable; low forces the effective counts to zero |
| xfer_busy | input | 1 | Serial transfer in progress |
| tx_level | input | CNT_W | Transmit FIFO entry count |
| rx_level | input | CNT_W | Receive FIFO entry count |
| tx_push_full | input | 1 | Pulse: write into a full transmit FIFO |
| rx_pop_empty | input | 1 | Pulse: read from an empty receive FIFO |
| rx_push_full | input | 1 | Pulse: received word arrived with the receive FIFO full |
| tx_wmark | input | THR_W | Transmit-empty interrupt threshold |
| rx_wmark | input | THR_W | Receive-full interrupt threshold |
| irq_enable | input | 5 | Per-source mask, 1 enables |
| irq_active_low | input | 1 | Combined interrupt polarity, 1 = active low |
| clr_stb | input | 1 | Clear strobe |
| clr_bits | input | 4 | Write-one clear vector |
| dma_tx_on | input | 1 | Transmit DMA enable |
| dma_rx_on | input | 1 | Receive DMA enable |
| dma_tx_mark | input | THR_W | Transmit DMA level |
| dma_rx_mark | input | THR_W | Receive DMA level |
| dma_tx_ack | input | 1 | Transmit DMA acknowledge |
| dma_rx_ack | input | 1 | Receive DMA acknowledge |
| stat_word | output | 5 | Status flags |
| raw_irq | output | 5 | Raw interrupt sources |
| irq_masked | output | 5 | Masked interrupt sources |
| irq_tx_empty | output | 1 | Masked transmit-empty interrupt |
| irq_tx_ovf | output | 1 | Masked transmit overflow interrupt |
| irq_rx_unf | output | 1 | Masked receive underflow interrupt |
| irq_rx_ovf | output | 1 | Masked receive overflow interrupt |
| irq_rx_full | output | 1 | Masked receive-full interrupt |
| irq_any | output | 1 | Combined interrupt at selected polarity |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The assertions assume that the entry counts never exceed the FIFO depth of 32. They also assume that the error pulses, the clear strobe and the acknowledges are sampled as single-cycle levels on the rising edge. The stimulus draws counts only from 0 to 32. It changes every input only on the falling edge and raises each error pulse and clear strobe for one cycle at a time, so the sticky cells and the acknowledge gating always see clean single-cycle events. Directed cases cover both threshold edges, the threshold of 31, a set and a clear in the same cycle, and a disable with full FIFOs.

// File: rtl/wmk_pkg.sv
package wmk_pkg;
  localparam int SRC_N   = 5;
  localparam int SRC_TXE = 0;
  localparam int SRC_TXO = 1;
  localparam int SRC_RXU = 2;
  localparam int SRC_RXO = 3;
  localparam int SRC_RXF = 4;

  localparam int CLR_W   = 4;
  localparam int CLR_ALL = 0;
  localparam int CLR_RXU = 1;
  localparam int CLR_RXO = 2;
  localparam int CLR_TXO = 3;

  localparam logic [4:0] STAT_RST = 5'b01100;

  typedef enum logic {
    CMP_AT_OR_BELOW = 1'b0,
    CMP_ABOVE_PLUS1 = 1'b1
  } cmp_mode_e;
endpackage

// File: rtl/wmk_level_cmp.sv
module wmk_level_cmp
  import wmk_pkg::*;
#(
  parameter int        CNT_W = 6,
  parameter int        THR_W = 5,
  parameter cmp_mode_e MODE  = CMP_AT_OR_BELOW
) (
  input  logic [CNT_W-1:0] count,
  input  logic [THR_W-1:0] thr,
  output logic             hit
);
  localparam int W = ((CNT_W > THR_W) ? CNT_W : THR_W) + 1;

  logic [W-1:0] cnt_x;
  logic [W-1:0] thr_x;

  assign cnt_x = W'(count);
  assign thr_x = W'(thr);

  generate
    if (MODE == CMP_AT_OR_BELOW) begin : g_le
      assign hit = (cnt_x <= thr_x);
    end else begin : g_ge1
      assign hit = (cnt_x >= (thr_x + W'(1)));
    end
  endgenerate
endmodule

// File: rtl/wmk_sticky.sv
module wmk_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  logic q_d;

  always_comb begin
    q_d = q;
    if (clr_i) q_d = 1'b0;
    if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end
endmodule

// File: rtl/wmk_irq_merge.sv
module wmk_irq_merge #(
  parameter int N = 5
) (
  input  logic [N-1:0] raw,
  input  logic [N-1:0] mask,
  input  logic         active_low,
  output logic [N-1:0] masked,
  output logic         combined
);
  logic any_hit;

  always_comb begin
    masked   = raw & mask;
    any_hit  = |masked;
    combined = active_low ? ~any_hit : any_hit;
  end
endmodule

// File: rtl/wmk_dma_req.sv
module wmk_dma_req (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic level_hit,
  input  logic ack,
  output logic req
);
  logic req_d;

  always_comb begin
    req_d = enable & level_hit & ~ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= req_d;
  end
endmodule

// File: rtl/fifo_irq_dma_ctl.sv
module fifo_irq_dma_ctl
  import wmk_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int THR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_en,
  input  logic             xfer_busy,
  input  logic [CNT_W-1:0] tx_level,
  input  logic [CNT_W-1:0] rx_level,
  input  logic             tx_push_full,
  input  logic             rx_pop_empty,
  input  logic             rx_push_full,
  input  logic [THR_W-1:0] tx_wmark,
  input  logic [THR_W-1:0] rx_wmark,
  input  logic [4:0]       irq_enable,
  input  logic             irq_active_low,
  input  logic             clr_stb,
  input  logic [3:0]       clr_bits,
  input  logic             dma_tx_on,
  input  logic             dma_rx_on,
  input  logic [THR_W-1:0] dma_tx_mark,
  input  logic [THR_W-1:0] dma_rx_mark,
  input  logic             dma_tx_ack,
  input  logic             dma_rx_ack,
  output logic [4:0]       stat_word,
  output logic [4:0]       raw_irq,
  output logic [4:0]       irq_masked,
  output logic             irq_tx_empty,
  output logic             irq_tx_ovf,
  output logic             irq_rx_unf,
  output logic             irq_rx_ovf,
  output logic             irq_rx_full,
  output logic             irq_any,
  output logic             dma_tx_req,
  output logic             dma_rx_req
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  // effective counts: a disabled controller sees empty FIFOs
  logic [CNT_W-1:0] tx_eff;
  logic [CNT_W-1:0] rx_eff;

  always_comb begin
    tx_eff = ctl_en ? tx_level : '0;
    rx_eff = ctl_en ? rx_level : '0;
  end

  // watermark comparators
  logic txe_hit, rxf_hit, dtx_hit, drx_hit;

  wmk_level_cmp #(.CNT_W(CNT_W), .THR_W(THR_W), .MODE(CMP_AT_OR_BELOW)) u_txe_cmp (
    .count(tx_eff), .thr(tx_wmark), .hit(txe_hit));
  wmk_level_cmp #(.CNT_W(CNT_W), .THR_W(THR_W), .MODE(CMP_ABOVE_PLUS1)) u_rxf_cmp (
    .count(rx_eff), .thr(rx_wmark), .hit(rxf_hit));
  wmk_level_cmp #(.CNT_W(CNT_W), .THR_W(THR_W), .MODE(CMP_AT_OR_BELOW)) u_dtx_cmp (
    .count(tx_eff), .thr(dma_tx_mark), .hit(dtx_hit));
  wmk_level_cmp #(.CNT_W(CNT_W), .THR_W(THR_W), .MODE(CMP_ABOVE_PLUS1)) u_drx_cmp (
    .count(rx_eff), .thr(dma_rx_mark), .hit(drx_hit));

  // level-driven raw flags, registered
  logic txe_q, txe_d;
  logic rxf_q, rxf_d;

  always_comb begin
    txe_d = txe_hit;
    rxf_d = rxf_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe_q <= 1'b1;
      rxf_q <= 1'b0;
    end else begin
      txe_q <= txe_d;
      rxf_q <= rxf_d;
    end
  end

  // sticky error flags with write-one clear
  logic clr_all;
  logic txo_clr, rxu_clr, rxo_clr;
  logic txo_q, rxu_q, rxo_q;

  always_comb begin
    clr_all = clr_stb & clr_bits[CLR_ALL];
    txo_clr = clr_all | (clr_stb & clr_bits[CLR_TXO]);
    rxu_clr = clr_all | (clr_stb & clr_bits[CLR_RXU]);
    rxo_clr = clr_all | (clr_stb & clr_bits[CLR_RXO]);
  end

  wmk_sticky u_txo (.clk(clk), .rst_n(rst_n), .set_i(tx_push_full), .clr_i(txo_clr), .q(txo_q));
  wmk_sticky u_rxu (.clk(clk), .rst_n(rst_n), .set_i(rx_pop_empty), .clr_i(rxu_clr), .q(rxu_q));
  wmk_sticky u_rxo (.clk(clk), .rst_n(rst_n), .set_i(rx_push_full), .clr_i(rxo_clr), .q(rxo_q));

  always_comb begin
    raw_irq          = '0;
    raw_irq[SRC_TXE] = txe_q;
    raw_irq[SRC_TXO] = txo_q;
    raw_irq[SRC_RXU] = rxu_q;
    raw_irq[SRC_RXO] = rxo_q;
    raw_irq[SRC_RXF] = rxf_q;
  end

  // status word
  logic [4:0] stat_q, stat_d;

  always_comb begin
    stat_d[0] = xfer_busy;
    stat_d[1] = (tx_eff == FULL_CNT);
    stat_d[2] = (tx_eff == '0);
    stat_d[3] = (rx_eff == '0);
    stat_d[4] = (rx_eff == FULL_CNT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= STAT_RST;
    else        stat_q <= stat_d;
  end

  assign stat_word = stat_q;

  // masking, combining and polarity
  wmk_irq_merge #(.N(SRC_N)) u_merge (
    .raw(raw_irq), .mask(irq_enable), .active_low(irq_active_low),
    .masked(irq_masked), .combined(irq_any));

  assign irq_tx_empty = irq_masked[SRC_TXE];
  assign irq_tx_ovf   = irq_masked[SRC_TXO];
  assign irq_rx_unf   = irq_masked[SRC_RXU];
  assign irq_rx_ovf   = irq_masked[SRC_RXO];
  assign irq_rx_full  = irq_masked[SRC_RXF];

  // DMA requests
  wmk_dma_req u_dtx (.clk(clk), .rst_n(rst_n), .enable(dma_tx_on), .level_hit(dtx_hit),
                     .ack(dma_tx_ack), .req(dma_tx_req));
  wmk_dma_req u_drx (.clk(clk), .rst_n(rst_n), .enable(dma_rx_on), .level_hit(drx_hit),
                     .ack(dma_rx_ack), .req(dma_rx_req));
endmodule

// File: rtl/wmk_checker.sv
module wmk_checker #(
  parameter int CNT_W = 6,
  parameter int THR_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_en,
  input logic [CNT_W-1:0] tx_level,
  input logic [THR_W-1:0] tx_wmark,
  input logic             tx_push_full,
  input logic             clr_stb,
  input logic [3:0]       clr_bits,
  input logic             irq_active_low,
  input logic             dma_tx_ack,
  input logic             dma_rx_ack,
  input logic [4:0]       stat_word,
  input logic [4:0]       raw_irq,
  input logic [4:0]       irq_masked,
  input logic             irq_any,
  input logic             dma_tx_req,
  input logic             dma_rx_req
);
  // R2: a transmit count at or below the threshold raises the raw bit next cycle
  a_r2_txe_level: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && (CNT_W'(tx_level) <= CNT_W'(tx_wmark))) |=> raw_irq[0]);

  // R4: overflow pulse sets the sticky bit
  a_r4_txo_set: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push_full |=> raw_irq[1]);

  // R4: sticky bit holds without a matching clear
  a_r4_txo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_irq[1] && !(clr_stb && (clr_bits[3] || clr_bits[0]))) |=> raw_irq[1]);

  // R5: clear without a colliding set drops the flag
  a_r5_txo_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && clr_bits[3] && !tx_push_full) |=> !raw_irq[1]);

  // R7: with nothing masked through, the combined line sits at its inactive level
  a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_masked == 5'b0) |-> (irq_any == irq_active_low));

  // R8: acknowledge drops the transmit request on the next edge
  a_r8_tx_ack: assert property (@(posedge clk) disable iff (!rst_n)
    dma_tx_ack |=> !dma_tx_req);

  // R9: acknowledge drops the receive request on the next edge
  a_r9_rx_ack: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx_ack |=> !dma_rx_req);

  // R10: transmit full and empty are never reported together
  a_r10_tx_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_word[1] && stat_word[2]));

  // R11: a disabled controller reports empty FIFOs
  a_r11_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> (stat_word[2] && stat_word[3] && !stat_word[1] && !stat_word[4] && raw_irq[0] && !raw_irq[4]));
endmodule

bind fifo_irq_dma_ctl wmk_checker #(.CNT_W(CNT_W), .THR_W(THR_W)) u_wmk_chk (
  .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .tx_level(tx_level), .tx_wmark(tx_wmark),
  .tx_push_full(tx_push_full), .clr_stb(clr_stb), .clr_bits(clr_bits),
  .irq_active_low(irq_active_low), .dma_tx_ack(dma_tx_ack), .dma_rx_ack(dma_rx_ack),
  .stat_word(stat_word), .raw_irq(raw_irq), .irq_masked(irq_masked), .irq_any(irq_any),
  .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req));

// File: tb/tb_fifo_irq_dma_ctl.sv
module tb_fifo_irq_dma_ctl;
  localparam int DEPTH = 32;
  localparam int CNT_W = 6;
  localparam int THR_W = 5;

  logic clk;
  logic rst_n;
  logic ctl_en, xfer_busy;
  logic [CNT_W-1:0] tx_level, rx_level;
  logic tx_push_full, rx_pop_empty, rx_push_full;
  logic [THR_W-1:0] tx_wmark, rx_wmark, dma_tx_mark, dma_rx_mark;
  logic [4:0] irq_enable;
  logic irq_active_low, clr_stb;
  logic [3:0] clr_bits;
  logic dma_tx_on, dma_rx_on, dma_tx_ack, dma_rx_ack;
  logic [4:0] stat_word, raw_irq, irq_masked;
  logic irq_tx_empty, irq_tx_ovf, irq_rx_unf, irq_rx_ovf, irq_rx_full, irq_any;
  logic dma_tx_req, dma_rx_req;

  int n_chk = 0;
  int n_fail = 0;

  // expected state
  logic [4:0] m_stat;
  logic m_txe, m_rxf, m_txo, m_rxu, m_rxo, m_dtx, m_drx;

  fifo_irq_dma_ctl #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .xfer_busy(xfer_busy),
    .tx_level(tx_level), .rx_level(rx_level), .tx_push_full(tx_push_full),
    .rx_pop_empty(rx_pop_empty), .rx_push_full(rx_push_full), .tx_wmark(tx_wmark),
    .rx_wmark(rx_wmark), .irq_enable(irq_enable), .irq_active_low(irq_active_low),
    .clr_stb(clr_stb), .clr_bits(clr_bits), .dma_tx_on(dma_tx_on), .dma_rx_on(dma_rx_on),
    .dma_tx_mark(dma_tx_mark), .dma_rx_mark(dma_rx_mark), .dma_tx_ack(dma_tx_ack),
    .dma_rx_ack(dma_rx_ack), .stat_word(stat_word), .raw_irq(raw_irq),
    .irq_masked(irq_masked), .irq_tx_empty(irq_tx_empty), .irq_tx_ovf(irq_tx_ovf),
    .irq_rx_unf(irq_rx_unf), .irq_rx_ovf(irq_rx_ovf), .irq_rx_full(irq_rx_full),
    .irq_any(irq_any), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff(logic en, logic [CNT_W-1:0] c);
    return en ? int'(c) : 0;
  endfunction

  function automatic logic [4:0] exp_raw();
    return {m_rxf, m_rxo, m_rxu, m_txo, m_txe};
  endfunction

  function automatic logic exp_any(logic [4:0] r, logic [4:0] m, logic pol);
    return (|(r & m)) ^ pol;
  endfunction

  task automatic model_update();
    int te, re;
    logic ca;
    te = eff(ctl_en, tx_level);
    re = eff(ctl_en, rx_level);
    ca = clr_stb & clr_bits[0];
    m_txe = (te <= int'(tx_wmark));
    m_rxf = (re >= int'(rx_wmark) + 1);
    m_txo = tx_push_full | (m_txo & ~(ca | (clr_stb & clr_bits[3])));
    m_rxo = rx_push_full | (m_rxo & ~(ca | (clr_stb & clr_bits[2])));
    m_rxu = rx_pop_empty | (m_rxu & ~(ca | (clr_stb & clr_bits[1])));
    m_stat = {re == DEPTH, re == 0, te == 0, te == DEPTH, xfer_busy};
    m_dtx = dma_tx_on & (te <= int'(dma_tx_mark)) & ~dma_tx_ack;
    m_drx = dma_rx_on & (re >= int'(dma_rx_mark) + 1) & ~dma_rx_ack;
  endtask

  task automatic check_all();
    logic [4:0] r;
    r = exp_raw();
    chk("R10 status word", stat_word, m_stat);
    chk("R2 tx-empty raw", raw_irq[0], r[0]);
    chk("R3 rx-full raw", raw_irq[4], r[4]);
    chk("R4 sticky raw", raw_irq[3:1], r[3:1]);
    chk("R6 masked vector", irq_masked, r & irq_enable);
    chk("R6 individual pins",
        {irq_rx_full, irq_rx_ovf, irq_rx_unf, irq_tx_ovf, irq_tx_empty}, r & irq_enable);
    chk("R7 combined", irq_any, exp_any(r, irq_enable, irq_active_low));
    chk("R8 tx dma req", dma_tx_req, m_dtx);
    chk("R9 rx dma req", dma_rx_req, m_drx);
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    check_all();
  endtask

  task automatic quiet_pulses();
    tx_push_full = 0; rx_pop_empty = 0; rx_push_full = 0;
    clr_stb = 0; clr_bits = 0; dma_tx_ack = 0; dma_rx_ack = 0;
  endtask

  // watchdog
  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0; ctl_en = 0; xfer_busy = 0; tx_level = 0; rx_level = 0;
    tx_wmark = 0; rx_wmark = 0; dma_tx_mark = 0; dma_rx_mark = 0;
    irq_enable = 0; irq_active_low = 0; dma_tx_on = 0; dma_rx_on = 0;
    quiet_pulses();
    m_stat = 5'b01100; m_txe = 1; m_rxf = 0; m_txo = 0; m_rxu = 0; m_rxo = 0;
    m_dtx = 0; m_drx = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset status", stat_word, 5'h0C);
    chk("R1 reset raw", raw_irq, 5'h01);
    chk("R1 reset dma", {dma_tx_req, dma_rx_req}, 0);
    rst_n = 1;
    irq_enable = 5'h1F;
    ctl_en = 1;

    // R2 boundary: count equal to threshold, then one above
    tx_level = 5; tx_wmark = 5; step();
    chk("R2 at threshold", raw_irq[0], 1);
    tx_level = 6; step();
    chk("R2 above threshold", raw_irq[0], 0);

    // R3 boundary
    rx_level = 7; rx_wmark = 7; step();
    chk("R3 equal to threshold", raw_irq[4], 0);
    rx_level = 8; step();
    chk("R3 threshold plus one", raw_irq[4], 1);
    rx_wmark = 31; rx_level = 31; step();
    chk("R3 threshold 31 at 31", raw_irq[4], 0);
    rx_level = 32; step();
    chk("R3 threshold 31 at 32", raw_irq[4], 1);

    // R4 set and hold, R5 clears
    tx_push_full = 1; rx_pop_empty = 1; rx_push_full = 1; step();
    quiet_pulses(); step(); step();
    chk("R4 all sticky held", raw_irq[3:1], 3'b111);
    clr_stb = 1; clr_bits = 4'b1000; step(); quiet_pulses();
    chk("R5 clear bit 3 tx overflow", raw_irq[3:1], 3'b110);
    clr_stb = 1; clr_bits = 4'b0010; step(); quiet_pulses();
    chk("R5 clear bit 1 rx underflow", raw_irq[3:1], 3'b100);
    clr_stb = 1; clr_bits = 4'b1111; tx_push_full = 1; step(); quiet_pulses();
    chk("R5 set wins over clear", raw_irq[3:1], 3'b001);
    chk("R5 level bits untouched", {raw_irq[4], raw_irq[0]}, {m_rxf, m_txe});
    clr_stb = 1; clr_bits = 4'b0001; step(); quiet_pulses();
    chk("R5 combined clear", raw_irq[3:1], 3'b000);

    // R7 polarity
    irq_enable = 5'h10; irq_active_low = 1; step();
    chk("R7 active low asserted", irq_any, 0);
    irq_enable = 5'h00; step();
    chk("R7 active low idle", irq_any, 1);
    irq_active_low = 0;

    // R8 / R9 acknowledge
    dma_tx_on = 1; dma_tx_mark = 31; tx_level = 3; step();
    chk("R8 tx request up", dma_tx_req, 1);
    dma_tx_ack = 1; step(); quiet_pulses();
    chk("R8 tx request dropped by ack", dma_tx_req, 0);
    dma_rx_on = 1; dma_rx_mark = 4; rx_level = 5; step();
    chk("R9 rx request up", dma_rx_req, 1);
    dma_rx_ack = 1; step(); quiet_pulses();
    chk("R9 rx request dropped by ack", dma_rx_req, 0);

    // R11 disable with full FIFOs
    tx_level = 32; rx_level = 32; step();
    chk("R10 both full", stat_word[4:1], 4'b1001);
    ctl_en = 0; step();
    chk("R11 disabled status", stat_word[4:1], 4'b0110);
    chk("R11 disabled raw", {raw_irq[4], raw_irq[0]}, 2'b01);
    ctl_en = 1;

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      ctl_en         = ($urandom_range(15, 0) != 0);
      xfer_busy      = 1'($urandom);
      tx_level       = CNT_W'($urandom_range(DEPTH, 0));
      rx_level       = CNT_W'($urandom_range(DEPTH, 0));
      tx_wmark       = THR_W'($urandom);
      rx_wmark       = THR_W'($urandom);
      dma_tx_mark    = THR_W'($urandom);
      dma_rx_mark    = THR_W'($urandom);
      irq_enable     = 5'($urandom);
      irq_active_low = 1'($urandom);
      dma_tx_on      = 1'($urandom);
      dma_rx_on      = 1'($urandom);
      tx_push_full   = ($urandom_range(9, 0) == 0);
      rx_pop_empty   = ($urandom_range(9, 0) == 0);
      rx_push_full   = ($urandom_range(9, 0) == 0);
      clr_stb        = ($urandom_range(5, 0) == 0);
      clr_bits       = 4'($urandom);
      dma_tx_ack     = ($urandom_range(3, 0) == 0);
      dma_rx_ack     = ($urandom_range(3, 0) == 0);
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule